// File: doc/BRIEF.md
# FIFO Port DMA Request Controller

This block runs the request/acknowledge handshake between an external DMA controller and one FIFO port of a buffer controller that holds several pipes. Once it is enabled and pointed at a pipe other than pipe 0, it raises a DMA request while the buffer byte count is non-zero. It then takes one data element from the buffer for each qualifying strobe. It reports each element it accepts and how many bytes that element holds, keeps the remaining byte count, and flags the final element of the buffer.

There are two request modes. In cycle-steal mode the request drops for one clock after each element. In burst mode the request stays high until the buffer is empty. The transfer unit is one byte or two bytes. A form code chooses which external strobe combination counts as an acknowledge. The split-bus form is only allowed on port 0. Configuration arrives through a two-register write interface, and the buffer count is loaded through a plain load strobe.

Top module: `dma_port_req`

## Requirements
- R1: After reset, `dreq`, `dend` and `elem_take` are low, and `remain` and `cur_pipe` read 0.
- R2: While `cur_pipe` is 0, `dreq` stays low whatever the enable bit and the count are.
- R3: In burst mode (register 1 bit 1 = 1), `dreq` stays high across back-to-back accepted elements until `remain` reaches 0, and falls at that edge.
- R4: In cycle-steal mode (register 1 bit 1 = 0), `dreq` is low for exactly one clock after each accepted element. It is high again on the following clock if bytes remain.
- R5: Each accepted element lowers `remain` by 1 with an 8-bit unit (register 0 bit 3 = 0) and by 2 with a 16-bit unit (bit 3 = 1). A lone final byte in 16-bit mode lowers it by 1. `elem_bytes` shows the amount in the cycle of `elem_take`.
- R6: `dend` is high exactly while `dreq` is high and `remain` is no more than the unit size in bytes.
- R7: Register 0 bits [2:0] set the pipe. A write that comes while a transfer is active (enabled, pipe not 0, `remain` not 0) leaves `cur_pipe` unchanged. Otherwise the write takes effect at that edge.
- R8: Register 1 bits [3:2] select the acknowledge: 0 = `dack`; 1 = `dack` and `rw_stb` together; 2 = `cs_hit`; 3 = `split_stb`. The unselected strobes accept nothing.
- R9: With `PORT_ID` other than 0, writing form 3 keeps the previous form. With `PORT_ID` 0, form 3 is accepted.
- R10: Register 1 bit 0 enables requests. Clearing it drops `dreq` at the same edge as the write and keeps `remain`. Setting it again resumes the request.
- R11: `elem_take` is high only when a selected strobe meets a high `dreq`. `remain` changes only on `elem_take` or `buf_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 pipe/width, 1 enable/mode/form |
| cfg_wdata | input | 8 | Register write data |
| buf_load | input | 1 | Load buffer byte count |
| buf_count | input | CNT_W | Byte count to load |
| dack | input | 1 | DMA acknowledge |
| rw_stb | input | 1 | Read/write strobe |
| cs_hit | input | 1 | Decoded address plus chip select |
| split_stb | input | 1 | Split data bus strobe |
| dreq | output | 1 | DMA request |
| dend | output | 1 | Final element marker |
| elem_take | output | 1 | Element accepted this cycle |
| elem_bytes | output | 2 | Bytes in accepted element |
| cur_pipe | output | PIPE_W | Selected pipe |
| remain | output | CNT_W | Bytes left in buffer |

## Verification
`dreq` and `cur_pipe` follow a register write or a count load at the same rising edge that takes it. `remain` moves at the edge that closes an accepted element. `elem_take` and `elem_bytes` are combinational in the cycle the strobe is driven. Internal reset releases two edges after `rst_n` rises. The bench drives inputs on the falling edge and reads the request outputs at the next falling edge, after the edge that acts on them. It reads `elem_take` one time step after it drives the strobes. It also keeps a per-element running count, and that count predicts the request pattern for every width, mode, form and length from 1 to 6 bytes.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  typedef enum logic [1:0] {
    FORM_ACK    = 2'd0,
    FORM_ACK_RW = 2'd1,
    FORM_ADDRCS = 2'd2,
    FORM_SPLIT  = 2'd3
  } dma_form_e;

  localparam logic REG_PORTSEL = 1'b0;
  localparam logic REG_DMACFG  = 1'b1;

  typedef struct packed {
    logic      en;
    logic      burst;
    dma_form_e form;
    logic      wide;
  } dma_cfg_t;
endpackage

// File: rtl/dmareq_cfg.sv
module dmareq_cfg
  import dmareq_pkg::*;
#(
  parameter int PORT_ID = 0,
  parameter int PIPE_W  = 3,
  parameter int DW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  output dma_cfg_t          cfg_d,
  output dma_cfg_t          cfg_q,
  output logic [PIPE_W-1:0] pipe_d,
  output logic [PIPE_W-1:0] pipe_q
);
  dma_form_e form_new;

  always_comb begin
    cfg_d    = cfg_q;
    pipe_d   = pipe_q;
    form_new = dma_form_e'(wdata[3:2]);
    if (we && addr == REG_PORTSEL) begin
      cfg_d.wide = wdata[PIPE_W];
      if (!busy) pipe_d = wdata[PIPE_W-1:0];
    end
    if (we && addr == REG_DMACFG) begin
      cfg_d.en    = wdata[0];
      cfg_d.burst = wdata[1];
      if (PORT_ID == 0 || form_new != FORM_SPLIT) cfg_d.form = form_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pipe_q <= '0;
    end else if (we) begin
      cfg_q  <= cfg_d;
      pipe_q <= pipe_d;
    end
  end
endmodule

// File: rtl/dmareq_strobe.sv
module dmareq_strobe
  import dmareq_pkg::*;
(
  input  dma_form_e form,
  input  logic      dack,
  input  logic      rw_stb,
  input  logic      cs_hit,
  input  logic      split_stb,
  output logic      hit
);
  always_comb begin
    unique case (form)
      FORM_ACK:    hit = dack;
      FORM_ACK_RW: hit = dack & rw_stb;
      FORM_ADDRCS: hit = cs_hit;
      FORM_SPLIT:  hit = split_stb;
      default:     hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dmareq_count.sv
module dmareq_count #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             hit,
  input  logic             wide_q,
  input  logic             req_ok_d,
  input  logic             burst_d,
  output logic             dreq,
  output logic             dend,
  output logic             take,
  output logic [1:0]       take_bytes,
  output logic [CNT_W-1:0] remain
);
  logic [CNT_W-1:0] cnt_q, cnt_d, unit;
  logic             dreq_d;

  always_comb begin
    take       = dreq & hit;
    unit       = wide_q ? CNT_W'(2) : CNT_W'(1);
    take_bytes = (wide_q && cnt_q >= CNT_W'(2)) ? 2'd2 : 2'd1;
    cnt_d      = cnt_q;
    if (load)      cnt_d = load_val;
    else if (take) cnt_d = cnt_q - CNT_W'(take_bytes);
    dreq_d     = req_ok_d && (cnt_d != '0) && !(!burst_d && take);
    dend       = dreq && (cnt_q <= unit);
    remain     = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dreq  <= 1'b0;
    end else begin
      if (load || take) cnt_q <= cnt_d;
      dreq <= dreq_d;
    end
  end
endmodule

// File: rtl/dma_port_req.sv
module dma_port_req
  import dmareq_pkg::*;
#(
  parameter int PORT_ID = 0,
  parameter int PIPE_W  = 3,
  parameter int CNT_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              buf_load,
  input  logic [CNT_W-1:0]  buf_count,
  input  logic              dack,
  input  logic              rw_stb,
  input  logic              cs_hit,
  input  logic              split_stb,
  output logic              dreq,
  output logic              dend,
  output logic              elem_take,
  output logic [1:0]        elem_bytes,
  output logic [PIPE_W-1:0] cur_pipe,
  output logic [CNT_W-1:0]  remain
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  dma_cfg_t          cfg_d, cfg_q;
  logic [PIPE_W-1:0] pipe_d;
  logic              busy, hit, req_ok_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  assign busy     = cfg_q.en && (cur_pipe != '0) && (remain != '0);
  assign req_ok_d = cfg_d.en && (pipe_d != '0);

  dmareq_cfg #(.PORT_ID(PORT_ID), .PIPE_W(PIPE_W), .DW(8)) u_cfg (
    .clk(clk), .rst_n(rst_s), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .busy(busy), .cfg_d(cfg_d), .cfg_q(cfg_q),
    .pipe_d(pipe_d), .pipe_q(cur_pipe)
  );

  dmareq_strobe u_stb (
    .form(cfg_q.form), .dack(dack), .rw_stb(rw_stb),
    .cs_hit(cs_hit), .split_stb(split_stb), .hit(hit)
  );

  dmareq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .load(buf_load), .load_val(buf_count),
    .hit(hit), .wide_q(cfg_q.wide), .req_ok_d(req_ok_d),
    .burst_d(cfg_d.burst), .dreq(dreq), .dend(dend), .take(elem_take),
    .take_bytes(elem_bytes), .remain(remain)
  );
endmodule

// File: rtl/dma_port_req_chk.sv
module dma_port_req_chk #(
  parameter int PIPE_W = 3,
  parameter int CNT_W  = 12
) (
  input logic              clk,
  input logic              rst_s,
  input logic              dreq,
  input logic              dend,
  input logic              elem_take,
  input logic [1:0]        elem_bytes,
  input logic [CNT_W-1:0]  remain,
  input logic [PIPE_W-1:0] cur_pipe,
  input logic              buf_load,
  input logic              cfg_we,
  input logic              cfg_addr,
  input logic              busy,
  input logic              burst_q
);
  a_r2_pipe0_no_req: assert property (@(posedge clk) disable iff (!rst_s)
    (cur_pipe == '0) |-> !dreq);

  a_r4_gap_after_take: assert property (@(posedge clk) disable iff (!rst_s)
    (!burst_q && elem_take && !cfg_we) |=> !dreq);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_s)
    (elem_take && !buf_load) |=> (remain == $past(remain) - CNT_W'($past(elem_bytes))));

  a_r6_end_with_req: assert property (@(posedge clk) disable iff (!rst_s)
    dend |-> dreq);

  a_r7_pipe_locked: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && cfg_we && cfg_addr == 1'b0) |=> $stable(cur_pipe));

  a_r11_count_held: assert property (@(posedge clk) disable iff (!rst_s)
    (!elem_take && !buf_load) |=> $stable(remain));

  a_r11_take_needs_req: assert property (@(posedge clk) disable iff (!rst_s)
    elem_take |-> dreq);
endmodule

bind dma_port_req dma_port_req_chk #(.PIPE_W(PIPE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .dreq(dreq), .dend(dend), .elem_take(elem_take),
  .elem_bytes(elem_bytes), .remain(remain), .cur_pipe(cur_pipe),
  .buf_load(buf_load), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .busy(busy),
  .burst_q(cfg_q.burst)
);

// File: tb/dma_port_req_tb.sv
module dma_port_req_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n, cfg_we, cfg_addr, buf_load, dack, rw_stb, cs_hit, split_stb;
  logic [7:0] cfg_wdata;
  logic [CNT_W-1:0] buf_count;
  logic dreq, dend, elem_take, dreq1, dend1, take1;
  logic [1:0] elem_bytes, bytes1;
  logic [2:0] cur_pipe, pipe1;
  logic [CNT_W-1:0] remain, remain1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_port_req #(.PORT_ID(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .buf_load(buf_load), .buf_count(buf_count),
    .dack(dack), .rw_stb(rw_stb), .cs_hit(cs_hit), .split_stb(split_stb),
    .dreq(dreq), .dend(dend), .elem_take(elem_take), .elem_bytes(elem_bytes),
    .cur_pipe(cur_pipe), .remain(remain));

  dma_port_req #(.PORT_ID(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .buf_load(buf_load), .buf_count(buf_count),
    .dack(dack), .rw_stb(rw_stb), .cs_hit(cs_hit), .split_stb(split_stb),
    .dreq(dreq1), .dend(dend1), .elem_take(take1), .elem_bytes(bytes1),
    .cur_pipe(pipe1), .remain(remain1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic load(input int n);
    buf_load = 1'b1; buf_count = CNT_W'(n);
    tick();
    buf_load = 1'b0;
  endtask

  task automatic strobes(input logic a, input logic r, input logic c, input logic s);
    dack = a; rw_stb = r; cs_hit = c; split_stb = s;
  endtask

  task automatic strobe_form(input int form, input logic on);
    case (form)
      0: strobes(on, 1'b0, 1'b0, 1'b0);
      1: strobes(on, on, 1'b0, 1'b0);
      2: strobes(1'b0, 1'b0, on, 1'b0);
      default: strobes(1'b0, 1'b0, 1'b0, on);
    endcase
  endtask

  task automatic drain(input int form);
    strobe_form(form, 1'b1);
    for (int i = 0; i < 64 && remain != 0; i++) tick();
    strobe_form(form, 1'b0);
    tick();
  endtask

  // R3 R4 R5 R6 R8 R11: full transfer with the selected strobe held high
  task automatic run_xfer(input bit wide, input bit burst, input int form, input int cnt);
    int rem, unit, step;
    bit last_acc, exp_req;
    wr(1'b0, {4'b0, wide, 3'd5});
    wr(1'b1, {4'b0, 2'(form), burst, 1'b1});
    load(cnt);
    rem = cnt; last_acc = 0; unit = wide ? 2 : 1;
    for (int g = 0; g < 40 && rem != 0; g++) begin
      exp_req = !(!burst && last_acc);
      chk(dreq == exp_req, burst ? "R3 dreq held" : "R4 dreq gap", dreq, exp_req);
      chk(dend == (exp_req && rem <= unit), "R6 dend", dend, exp_req && rem <= unit);
      chk(remain == CNT_W'(rem), "R5 remain", remain, rem);
      strobe_form(form, 1'b1);
      #1;
      step = (wide && rem >= 2) ? 2 : 1;
      chk(elem_take == exp_req, "R8 take on selected strobe", elem_take, exp_req);
      if (exp_req) chk(elem_bytes == 2'(step), "R5 elem_bytes", elem_bytes, step);
      tick();
      if (exp_req) rem -= step;
      last_acc = exp_req;
    end
    strobe_form(form, 1'b0);
    chk(dreq == 1'b0, "R3 dreq low when empty", dreq, 0);
    chk(remain == 0, "R5 remain empty", remain, 0);
    wr(1'b1, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    buf_load = 0; buf_count = 0;
    strobes(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(dreq == 0, "R1 dreq", dreq, 0);
    chk(dend == 0, "R1 dend", dend, 0);
    chk(elem_take == 0, "R1 elem_take", elem_take, 0);
    chk(remain == 0, "R1 remain", remain, 0);
    chk(cur_pipe == 0, "R1 cur_pipe", cur_pipe, 0);

    // R2: pipe 0 never requests
    wr(1'b1, 8'h03);
    load(3);
    for (int i = 0; i < 3; i++) begin
      chk(dreq == 0, "R2 pipe0 dreq", dreq, 0);
      tick();
    end
    chk(remain == 3, "R2 remain kept", remain, 3);
    wr(1'b0, 8'h03);
    chk(cur_pipe == 3, "R7 idle pipe write", cur_pipe, 3);
    chk(dreq == 1, "R2 request after pipe set", dreq, 1);
    // R7: pipe write ignored while active
    wr(1'b0, 8'h06);
    chk(cur_pipe == 3, "R7 pipe locked", cur_pipe, 3);
    drain(0);
    wr(1'b1, 8'h00);

    // sweep
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < 2; b++)
        for (int f = 0; f < 4; f++)
          for (int c = 1; c <= 6; c++)
            run_xfer(w[0], b[0], f, c);

    // R8: unselected strobes do nothing
    wr(1'b0, 8'h02);
    wr(1'b1, {4'b0, 2'd1, 1'b1, 1'b1});
    load(4);
    strobes(1, 0, 1, 1); tick();
    chk(remain == 4, "R8 dack alone ignored", remain, 4);
    strobes(0, 1, 1, 1); tick();
    chk(remain == 4, "R8 rw alone ignored", remain, 4);
    chk(dreq == 1, "R8 dreq still high", dreq, 1);
    strobes(1, 1, 0, 0); tick();
    chk(remain == 3, "R8 dack+rw accepted", remain, 3);
    strobes(0, 0, 0, 0);
    // R10: disable keeps count
    wr(1'b1, {4'b0, 2'd1, 1'b1, 1'b0});
    chk(dreq == 0, "R10 dreq dropped", dreq, 0);
    strobes(1, 1, 0, 0); tick();
    chk(remain == 3, "R10 remain kept", remain, 3);
    strobes(0, 0, 0, 0);
    wr(1'b1, {4'b0, 2'd1, 1'b1, 1'b1});
    chk(dreq == 1, "R10 resumed", dreq, 1);
    chk(remain == 3, "R10 remain after resume", remain, 3);
    drain(1);

    // R9: form 3 rejected on port 1, accepted on port 0
    wr(1'b1, {4'b0, 2'd2, 1'b1, 1'b0});
    wr(1'b1, {4'b0, 2'd3, 1'b1, 1'b1});
    load(2);
    strobes(0, 0, 0, 1); tick();
    chk(remain == 1, "R9 port0 split accepted", remain, 1);
    chk(remain1 == 2, "R9 port1 split ignored", remain1, 2);
    strobes(0, 0, 1, 0); tick();
    chk(remain1 == 1, "R9 port1 keeps form 2", remain1, 1);
    chk(remain == 1, "R9 port0 cs ignored", remain, 1);
    strobes(0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule